// File: doc/BRIEF.md
# UART In-Band Flow Control Unit

This unit sits beside one UART channel and handles software (in-band) flow control in both directions. On the local side it watches the fill level of the receive FIFO. When the level climbs past an upper threshold it queues an "off" control character for the transmitter. Once the host has drained the FIFO below a lower threshold, it queues an "on" character. On the remote side it inspects every received character. It swallows the programmed on/off characters and uses them to suspend or resume the draining of the transmit FIFO.

A 4-bit mode field selects the behaviour of each direction separately. The upper two bits pick what is transmitted, and the lower two bits pick what is recognised on receive. Each direction can be off, use the first character set, use the second character set, or use two-character sequences (first-set character followed by second-set character). The transmitter offers a slot with `tx_slot`. In reply, the unit registers one load pulse that carries either a control character or the head of the transmit FIFO. Control characters always win, even while FIFO data is suspended.

Top module: `uart_xonxoff_fc`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tx_load`, `tx_fifo_pop`, `rx_wr_en` and `tx_paused` are 0, and no off character is recorded as sent.
- R2: `fc_mode[3:2]` selects the transmitted characters: 2'b00 sends none, 2'b10 sends `off_a`/`on_a`, 2'b01 sends `off_b`/`on_b`, and 2'b11 sends `off_a` then `off_b`, or `on_a` then `on_b`, in that order.
- R3: With transmit control enabled, `rx_level` strictly above `thr_hi` queues one off sequence. No further off sequence is sent until an on sequence has been queued.
- R4: An on sequence is queued only after an off sequence, and only when `rx_level` is strictly below `thr_lo`. Levels from `thr_lo` to `thr_hi` queue nothing. Threshold checks happen only while no control character is waiting.
- R5: `fc_mode[1:0]` selects receive matching. 2'b10 matches `off_a`/`on_a` and 2'b01 matches `off_b`/`on_b`, with the off character checked first. Matched characters are not forwarded. Characters of the unselected set are forwarded.
- R6: In receive mode 2'b11, `on_a` or `off_a` is held as pending and not forwarded. A following `on_b` or `off_b` completes its own pair. Any other character drops the pending first character and is then evaluated afresh.
- R7: A matched off suspends the transmit FIFO from the next cycle: `tx_paused` is 1 and no `tx_fifo_pop` occurs. A matched on clears the suspension.
- R8: A waiting control character is loaded before FIFO data, and it is loaded even while the unit is suspended.
- R9: `tx_load` rises only in the cycle after `tx_slot` was 1, never in two consecutive cycles. `tx_fifo_pop` is 1 exactly when a FIFO byte is loaded, and FIFO bytes leave in FIFO order.
- R10: An unconsumed received character appears on `rx_wr_data` with `rx_wr_en` high exactly one cycle after its `rx_valid` strobe.
- R11: Receive mode 2'b00 forwards every character and clears any suspension and any pending first character.
- R12: All 16 values of `fc_mode` work, with the two directions independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_mode | input | 4 | [3:2] transmit selection, [1:0] receive selection |
| thr_hi | input | LVL_W | Upper receive-FIFO threshold |
| thr_lo | input | LVL_W | Lower receive-FIFO threshold |
| on_a | input | CHAR_W | First-set on character |
| on_b | input | CHAR_W | Second-set on character |
| off_a | input | CHAR_W | First-set off character |
| off_b | input | CHAR_W | Second-set off character |
| rx_level | input | LVL_W | Current receive FIFO fill count |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CHAR_W | Received character |
| rx_wr_en | output | 1 | Write strobe into the receive FIFO |
| rx_wr_data | output | CHAR_W | Character written into the receive FIFO |
| tx_slot | input | 1 | Transmitter can accept a character |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_fifo_data | input | CHAR_W | Head of the transmit FIFO (show-ahead) |
| tx_load | output | 1 | One-cycle load of `tx_char` into the transmitter |
| tx_char | output | CHAR_W | Character being loaded |
| tx_fifo_pop | output | 1 | Pops the transmit FIFO head |
| tx_paused | output | 1 | Transmit FIFO data is suspended |

## Verification
The hardest state to reach is a local off request that has to go out while the far end has already suspended the transmitter. At the same moment the transmitter is busy and FIFO data is still queued. The stimulus gets there in three steps: it delivers a matched off first, then queues FIFO bytes, then raises the receive level, so the control character must bypass the suspension in the next free slot. The bench also produces two-character receive patterns that break off after the first character, so a pending match must be dropped and the breaking character re-evaluated. Finally, it sweeps every mode value with mixed levels and received characters, and compares all outputs with a behavioural model on every cycle.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  // Direction selection codes (two bits per direction of fc_mode)
  localparam logic [1:0] SEL_OFF  = 2'b00;
  localparam logic [1:0] SEL_SETB = 2'b01;
  localparam logic [1:0] SEL_SETA = 2'b10;
  localparam logic [1:0] SEL_PAIR = 2'b11;

  // Pending state of the two-character receive matcher
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_ON   = 2'd1,
    PEND_OFF  = 2'd2
  } pend_e;

endpackage

// File: rtl/fc_level_watch.sv
module fc_level_watch
  import uart_fc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        tx_sel,
  input  logic [LVL_W-1:0]  thr_hi,
  input  logic [LVL_W-1:0]  thr_lo,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [CHAR_W-1:0] on_a,
  input  logic [CHAR_W-1:0] on_b,
  input  logic [CHAR_W-1:0] off_a,
  input  logic [CHAR_W-1:0] off_b,
  input  logic              ctl_take,
  output logic              ctl_valid,
  output logic [CHAR_W-1:0] ctl_char
);

  localparam int QCNT_W = 2;

  logic [QCNT_W-1:0] q_cnt;
  logic [CHAR_W-1:0] q_head;
  logic [CHAR_W-1:0] q_tail;
  logic              off_sent;
  logic              want_off;
  logic              want_on;

  assign want_off = (tx_sel != SEL_OFF) && !off_sent && (rx_level > thr_hi);
  assign want_on  = (tx_sel != SEL_OFF) &&  off_sent && (rx_level < thr_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt    <= '0;
      q_head   <= '0;
      q_tail   <= '0;
      off_sent <= 1'b0;
    end else if (ctl_take) begin
      q_head <= q_tail;
      q_cnt  <= q_cnt - 1'b1;
    end else if (q_cnt == '0) begin
      if (want_off) begin
        off_sent <= 1'b1;
        case (tx_sel)
          SEL_SETA: begin q_head <= off_a; q_cnt <= 2'd1; end
          SEL_SETB: begin q_head <= off_b; q_cnt <= 2'd1; end
          default:  begin q_head <= off_a; q_tail <= off_b; q_cnt <= 2'd2; end
        endcase
      end else if (want_on) begin
        off_sent <= 1'b0;
        case (tx_sel)
          SEL_SETA: begin q_head <= on_a; q_cnt <= 2'd1; end
          SEL_SETB: begin q_head <= on_b; q_cnt <= 2'd1; end
          default:  begin q_head <= on_a; q_tail <= on_b; q_cnt <= 2'd2; end
        endcase
      end
    end
  end

  assign ctl_valid = (q_cnt != '0);
  assign ctl_char  = q_head;

  p_queue_bound_r2: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= 2'd2);

  p_take_needs_char_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_take |-> ctl_valid);

  p_off_once_r3: assert property (@(posedge clk) disable iff (rst)
    (off_sent && !want_on) |=> off_sent);

endmodule

// File: rtl/fc_rx_match.sv
module fc_rx_match
  import uart_fc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rx_sel,
  input  logic [CHAR_W-1:0] on_a,
  input  logic [CHAR_W-1:0] on_b,
  input  logic [CHAR_W-1:0] off_a,
  input  logic [CHAR_W-1:0] off_b,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              paused,
  output logic              rx_wr_en,
  output logic [CHAR_W-1:0] rx_wr_data
);

  pend_e             pend, n_pend;
  logic              n_paused;
  logic              n_wr;
  logic [CHAR_W-1:0] one_on;
  logic [CHAR_W-1:0] one_off;

  assign one_on  = (rx_sel == SEL_SETA) ? on_a  : on_b;
  assign one_off = (rx_sel == SEL_SETA) ? off_a : off_b;

  always_comb begin
    n_paused = paused;
    n_pend   = pend;
    n_wr     = 1'b0;
    if (rx_sel == SEL_OFF) begin
      n_paused = 1'b0;
      n_pend   = PEND_NONE;
      n_wr     = rx_valid;
    end else if (rx_sel != SEL_PAIR) begin
      n_pend = PEND_NONE;
      if (rx_valid) begin
        if (rx_data == one_off)     n_paused = 1'b1;
        else if (rx_data == one_on) n_paused = 1'b0;
        else                        n_wr     = 1'b1;
      end
    end else if (rx_valid) begin
      if (pend == PEND_ON && rx_data == on_b) begin
        n_paused = 1'b0;
        n_pend   = PEND_NONE;
      end else if (pend == PEND_OFF && rx_data == off_b) begin
        n_paused = 1'b1;
        n_pend   = PEND_NONE;
      end else if (rx_data == on_a) begin
        n_pend = PEND_ON;
      end else if (rx_data == off_a) begin
        n_pend = PEND_OFF;
      end else begin
        n_pend = PEND_NONE;
        n_wr   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paused     <= 1'b0;
      pend       <= PEND_NONE;
      rx_wr_en   <= 1'b0;
      rx_wr_data <= '0;
    end else begin
      paused   <= n_paused;
      pend     <= n_pend;
      rx_wr_en <= n_wr;
      if (n_wr) rx_wr_data <= rx_data;
    end
  end

  p_off_mode_resumes_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_sel == SEL_OFF) |=> !paused);

  p_single_off_consumed_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sel == SEL_SETA && rx_data == off_a) |=> (!rx_wr_en && paused));

  p_write_follows_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    rx_wr_en |-> $past(rx_valid));

  p_pair_first_held_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sel == SEL_PAIR && rx_data == off_a) |=> !rx_wr_en);

endmodule

// File: rtl/fc_tx_arbiter.sv
module fc_tx_arbiter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_slot,
  input  logic              paused,
  input  logic              ctl_valid,
  input  logic [CHAR_W-1:0] ctl_char,
  input  logic              fifo_empty,
  input  logic [CHAR_W-1:0] fifo_data,
  output logic              ctl_take,
  output logic              tx_load,
  output logic [CHAR_W-1:0] tx_char,
  output logic              tx_fifo_pop
);

  logic slot_free;
  logic data_go;

  assign slot_free = tx_slot && !tx_load;
  assign ctl_take  = slot_free && ctl_valid;
  assign data_go   = slot_free && !ctl_valid && !paused && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_load     <= 1'b0;
      tx_char     <= '0;
      tx_fifo_pop <= 1'b0;
    end else begin
      tx_load     <= ctl_take || data_go;
      tx_fifo_pop <= data_go;
      if (ctl_take)     tx_char <= ctl_char;
      else if (data_go) tx_char <= fifo_data;
    end
  end

  p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);

  p_load_after_slot_r9: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(tx_slot));

  p_pop_with_load_r9: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_pop |-> tx_load);

  p_no_data_when_paused_r7: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_pop |-> !$past(paused));

endmodule

// File: rtl/uart_xonxoff_fc.sv
module uart_xonxoff_fc #(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        fc_mode,
  input  logic [LVL_W-1:0]  thr_hi,
  input  logic [LVL_W-1:0]  thr_lo,
  input  logic [CHAR_W-1:0] on_a,
  input  logic [CHAR_W-1:0] on_b,
  input  logic [CHAR_W-1:0] off_a,
  input  logic [CHAR_W-1:0] off_b,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rx_wr_en,
  output logic [CHAR_W-1:0] rx_wr_data,
  input  logic              tx_slot,
  input  logic              tx_fifo_empty,
  input  logic [CHAR_W-1:0] tx_fifo_data,
  output logic              tx_load,
  output logic [CHAR_W-1:0] tx_char,
  output logic              tx_fifo_pop,
  output logic              tx_paused
);

  logic              ctl_valid;
  logic [CHAR_W-1:0] ctl_char;
  logic              ctl_take;
  logic              paused;

  fc_level_watch #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_level (
    .clk       (clk),
    .rst       (rst),
    .tx_sel    (fc_mode[3:2]),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .rx_level  (rx_level),
    .on_a      (on_a),
    .on_b      (on_b),
    .off_a     (off_a),
    .off_b     (off_b),
    .ctl_take  (ctl_take),
    .ctl_valid (ctl_valid),
    .ctl_char  (ctl_char)
  );

  fc_rx_match #(.CHAR_W(CHAR_W)) u_match (
    .clk        (clk),
    .rst        (rst),
    .rx_sel     (fc_mode[1:0]),
    .on_a       (on_a),
    .on_b       (on_b),
    .off_a      (off_a),
    .off_b      (off_b),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .paused     (paused),
    .rx_wr_en   (rx_wr_en),
    .rx_wr_data (rx_wr_data)
  );

  fc_tx_arbiter #(.CHAR_W(CHAR_W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .tx_slot     (tx_slot),
    .paused      (paused),
    .ctl_valid   (ctl_valid),
    .ctl_char    (ctl_char),
    .fifo_empty  (tx_fifo_empty),
    .fifo_data   (tx_fifo_data),
    .ctl_take    (ctl_take),
    .tx_load     (tx_load),
    .tx_char     (tx_char),
    .tx_fifo_pop (tx_fifo_pop)
  );

  assign tx_paused = paused;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!tx_load && !tx_fifo_pop && !rx_wr_en && !tx_paused));

endmodule

// File: tb/uart_xonxoff_fc_bench.sv
module uart_xonxoff_fc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CHAR_CYC   = 4;
  localparam logic [7:0] C_ON_A  = 8'h11;
  localparam logic [7:0] C_ON_B  = 8'h12;
  localparam logic [7:0] C_OFF_A = 8'h13;
  localparam logic [7:0] C_OFF_B = 8'h14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] fc_mode = 4'b0000;
  logic [8:0] thr_hi = 9'd10;
  logic [8:0] thr_lo = 9'd4;
  logic [8:0] rx_level = 9'd0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_slot = 1'b0;
  logic       tx_fifo_empty = 1'b1;
  logic [7:0] tx_fifo_data = 8'h00;
  logic       rx_wr_en;
  logic [7:0] rx_wr_data;
  logic       tx_load;
  logic [7:0] tx_char;
  logic       tx_fifo_pop;
  logic       tx_paused;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_xonxoff_fc u_uart_xonxoff_fc (
    .clk(clk), .rst(rst), .fc_mode(fc_mode), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .on_a(C_ON_A), .on_b(C_ON_B), .off_a(C_OFF_A), .off_b(C_OFF_B),
    .rx_level(rx_level), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .tx_slot(tx_slot),
    .tx_fifo_empty(tx_fifo_empty), .tx_fifo_data(tx_fifo_data),
    .tx_load(tx_load), .tx_char(tx_char), .tx_fifo_pop(tx_fifo_pop),
    .tx_paused(tx_paused)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // bench-side environment
  logic [7:0] fifo_q[$];
  logic [7:0] sent_log[$];
  logic [7:0] rx_log[$];
  int         busy = 0;

  // reference model state (values the registered outputs should hold)
  logic       m_load, m_pop, m_wr, m_paused, m_sent;
  logic [7:0] m_char, m_wdata;
  logic [7:0] ctlq[$];
  int         m_pend; // 0 none, 1 first on seen, 2 first off seen

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit take, dgo, np, nw;
    logic [1:0] txs, rxs;
    logic [7:0] sel_on, sel_off;
    if (rst) begin
      m_load = 0; m_pop = 0; m_wr = 0; m_paused = 0; m_sent = 0;
      m_char = 0; m_wdata = 0; m_pend = 0; ctlq.delete();
      return;
    end
    txs = fc_mode[3:2];
    rxs = fc_mode[1:0];
    take = tx_slot && !m_load && ctlq.size() > 0;
    dgo  = tx_slot && !m_load && ctlq.size() == 0 && !m_paused && !tx_fifo_empty;
    if (take)     m_char = ctlq[0];
    else if (dgo) m_char = tx_fifo_data;
    if (take) void'(ctlq.pop_front());
    else if (ctlq.size() == 0 && txs != 2'b00) begin
      if (!m_sent && rx_level > thr_hi) begin
        m_sent = 1;
        if (txs != 2'b01) ctlq.push_back(C_OFF_A);
        if (txs != 2'b10) ctlq.push_back(C_OFF_B);
      end else if (m_sent && rx_level < thr_lo) begin
        m_sent = 0;
        if (txs != 2'b01) ctlq.push_back(C_ON_A);
        if (txs != 2'b10) ctlq.push_back(C_ON_B);
      end
    end
    np = m_paused; nw = 0;
    sel_on  = (rxs == 2'b10) ? C_ON_A  : C_ON_B;
    sel_off = (rxs == 2'b10) ? C_OFF_A : C_OFF_B;
    if (rxs == 2'b00) begin
      np = 0; m_pend = 0; nw = rx_valid;
    end else if (rxs != 2'b11) begin
      m_pend = 0;
      if (rx_valid) begin
        if (rx_data == sel_off)     np = 1;
        else if (rx_data == sel_on) np = 0;
        else                        nw = 1;
      end
    end else if (rx_valid) begin
      if (m_pend == 1 && rx_data == C_ON_B)       begin np = 0; m_pend = 0; end
      else if (m_pend == 2 && rx_data == C_OFF_B) begin np = 1; m_pend = 0; end
      else if (rx_data == C_ON_A)  m_pend = 1;
      else if (rx_data == C_OFF_A) m_pend = 2;
      else begin m_pend = 0; nw = 1; end
    end
    m_load = take || dgo;
    m_pop  = dgo;
    m_paused = np;
    m_wr = nw;
    if (nw) m_wdata = rx_data;
  endtask

  // one clock: model, edge, compare at negedge, update environment
  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tx_load === m_load, "R9", "tx_load", tx_load, m_load);
    if (m_load) chk(tx_char === m_char, "R2", "tx_char", tx_char, m_char);
    chk(tx_fifo_pop === m_pop, "R9", "tx_fifo_pop", tx_fifo_pop, m_pop);
    chk(rx_wr_en === m_wr, "R10", "rx_wr_en", rx_wr_en, m_wr);
    if (m_wr) chk(rx_wr_data === m_wdata, "R10", "rx_wr_data", rx_wr_data, m_wdata);
    chk(tx_paused === m_paused, "R7", "tx_paused", tx_paused, m_paused);
    if (tx_load) sent_log.push_back(tx_char);
    if (rx_wr_en) rx_log.push_back(rx_wr_data);
    if (m_pop && fifo_q.size() > 0) void'(fifo_q.pop_front());
    if (m_load) busy = CHAR_CYC;
    else if (busy > 0) busy--;
    tx_slot = (busy == 0);
    tx_fifo_empty = (fifo_q.size() == 0);
    tx_fifo_data = (fifo_q.size() > 0) ? fifo_q[0] : 8'h00;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic send_rx(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    cycle();
    rx_valid = 1'b0;
    cycle();
  endtask

  task automatic push_tx(input logic [7:0] d);
    fifo_q.push_back(d);
    tx_fifo_empty = 1'b0;
    tx_fifo_data = fifo_q[0];
  endtask

  function automatic int count_sent(input int from, input logic [7:0] v);
    int c = 0;
    for (int i = from; i < sent_log.size(); i++) if (sent_log[i] == v) c++;
    return c;
  endfunction

  function automatic int count_rx(input int from, input logic [7:0] v);
    int c = 0;
    for (int i = from; i < rx_log.size(); i++) if (rx_log[i] == v) c++;
    return c;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    int mark, rmark;
    @(negedge clk);
    run(3);
    rst = 1'b0;
    // R1: reset state, first cycle out of reset
    cycle();
    chk(!tx_load && !tx_fifo_pop && !rx_wr_en && !tx_paused, "R1", "quiet after reset",
        {tx_load, tx_fifo_pop, rx_wr_en, tx_paused}, 0);

    // R9: FIFO bytes leave in order, mode set A both ways
    fc_mode = 4'b1010;
    for (int i = 0; i < 6; i++) push_tx(8'h41 + 8'(i));
    mark = sent_log.size();
    run(40);
    chk(sent_log.size() - mark == 6, "R9", "bytes sent", sent_log.size() - mark, 6);
    chk(sent_log[mark] == 8'h41 && sent_log[mark+5] == 8'h46, "R9", "byte order",
        sent_log[mark], 8'h41);

    // R3 / R2: one off character per crossing
    mark = sent_log.size();
    rx_level = 9'd12;
    run(30);
    chk(count_sent(mark, C_OFF_A) == 1, "R3", "off_a count", count_sent(mark, C_OFF_A), 1);
    chk(count_sent(mark, C_OFF_B) == 0, "R2", "off_b count", count_sent(mark, C_OFF_B), 0);
    // R4: hysteresis band sends nothing
    mark = sent_log.size();
    rx_level = 9'd7;
    run(20);
    chk(sent_log.size() == mark, "R4", "nothing in band", sent_log.size() - mark, 0);
    rx_level = 9'd4;
    run(10);
    chk(sent_log.size() == mark, "R4", "nothing at lower threshold", sent_log.size() - mark, 0);
    rx_level = 9'd2;
    run(20);
    chk(count_sent(mark, C_ON_A) == 1, "R4", "on_a count", count_sent(mark, C_ON_A), 1);

    // R7 / R8: suspension, control character bypasses it
    send_rx(C_OFF_A);
    run(2);
    chk(tx_paused == 1'b1, "R7", "paused after off", tx_paused, 1);
    for (int i = 0; i < 4; i++) push_tx(8'h61 + 8'(i));
    mark = sent_log.size();
    run(25);
    chk(sent_log.size() == mark, "R7", "no data while paused", sent_log.size() - mark, 0);
    rx_level = 9'd20;
    run(20);
    chk(count_sent(mark, C_OFF_A) == 1 && sent_log.size() - mark == 1, "R8",
        "off sent while paused", sent_log.size() - mark, 1);
    mark = sent_log.size();
    send_rx(C_ON_A);
    run(40);
    chk(tx_paused == 1'b0 && count_sent(mark, 8'h64) == 1, "R7", "resume after on",
        tx_paused, 0);
    rx_level = 9'd0;
    run(20);

    // R10 / R5: forwarding and consumption
    rmark = rx_log.size();
    send_rx(8'h55);
    send_rx(C_ON_B);
    send_rx(C_ON_A);
    chk(count_rx(rmark, 8'h55) == 1, "R10", "plain char forwarded", count_rx(rmark, 8'h55), 1);
    chk(count_rx(rmark, C_ON_B) == 1, "R5", "other set forwarded", count_rx(rmark, C_ON_B), 1);
    chk(count_rx(rmark, C_ON_A) == 0, "R5", "match consumed", count_rx(rmark, C_ON_A), 0);

    // R2: pair transmit order
    fc_mode = 4'b1111;
    mark = sent_log.size();
    rx_level = 9'd15;
    run(30);
    chk(sent_log.size() - mark == 2 && sent_log[mark] == C_OFF_A && sent_log[mark+1] == C_OFF_B,
        "R2", "off pair order", sent_log.size() - mark, 2);
    mark = sent_log.size();
    rx_level = 9'd1;
    run(30);
    chk(sent_log.size() - mark == 2 && sent_log[mark] == C_ON_A && sent_log[mark+1] == C_ON_B,
        "R2", "on pair order", sent_log.size() - mark, 2);

    // R6: pair receive with broken pair
    rmark = rx_log.size();
    send_rx(C_OFF_A);
    send_rx(8'h5A);
    chk(tx_paused == 1'b0, "R6", "broken pair no pause", tx_paused, 0);
    chk(count_rx(rmark, 8'h5A) == 1 && count_rx(rmark, C_OFF_A) == 0, "R6",
        "breaker forwarded, first dropped", rx_log.size() - rmark, 1);
    send_rx(C_OFF_A);
    send_rx(C_OFF_B);
    chk(tx_paused == 1'b1, "R6", "full off pair pauses", tx_paused, 1);
    send_rx(C_ON_A);
    send_rx(C_OFF_A);
    send_rx(C_ON_B);
    chk(tx_paused == 1'b1, "R6", "re-evaluated pending blocks on", tx_paused, 1);

    // R11: receive mode off clears suspension
    fc_mode = 4'b1100;
    run(3);
    chk(tx_paused == 1'b0, "R11", "mode off resumes", tx_paused, 0);
    rmark = rx_log.size();
    send_rx(C_OFF_A);
    chk(count_rx(rmark, C_OFF_A) == 1, "R11", "off char forwarded", count_rx(rmark, C_OFF_A), 1);

    // R12: every mode value
    for (int m = 0; m < 16; m++) begin
      fc_mode = 4'b0000;
      rx_level = 9'd0;
      run(3);
      fc_mode = 4'(m);
      push_tx(8'h70 + 8'(m));
      rx_level = 9'd11;
      run(12);
      send_rx(8'h33);
      if (fc_mode[1:0] == 2'b01) send_rx(C_OFF_B);
      else begin
        send_rx(C_OFF_A);
        if (fc_mode[1:0] == 2'b11) send_rx(C_OFF_B);
      end
      push_tx(8'h20);
      rx_level = 9'd0;
      run(15);
      chk(tx_paused == (fc_mode[1:0] != 2'b00), "R12", $sformatf("mode %0d pause", m),
          tx_paused, fc_mode[1:0] != 2'b00);
      fc_mode = 4'b0000;
      run(20);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule